// File: doc/BRIEF.md
# Macro-op Cracker and Steering Unit

This block sits between the dispatch stage and the integer schedulers. Each cycle it is offered a group of up to `NUM_IN` macro-ops in program order, each described by a path class, an operation kind, a memory-operand flag, a vector-width flag and an opaque payload. It expands every macro-op into its micro-ops. Each micro-op goes either to the ALU scheduler queues or to the address-generation (load/store) scheduler queues, and the micro-ops are laid out on `3*NUM_IN` output lanes with the oldest first.

A compute macro-op with a memory source becomes a load followed by a compute micro-op. The two are linked by a dependency tag from a rolling counter. A macro-op of the two-macro-op class produces two operations. A wide (256-bit) vector operation is not doubled: it keeps the micro-op count of its class and only carries its width flag onward. A microcoded macro-op emits no micro-ops. It raises a single microcode-request token and is the last input taken that cycle.

The group is accepted whole or not at all. The number of ALU-bound and AGU-bound micro-ops is compared with the free-slot counts the queues report. If either count is too large, every `in_ready` bit stays low. Accepted micro-ops appear on the registered output lanes one cycle later.

Top module: `mop_crack_steer`

## Requirements
- R1: During and after synchronous reset, every output lane and the microcode token are invalid with all fields zero, and the dependency tag counter restarts at 0.
- R2: A single-class macro-op of compute kind (kind 0 or 3) without a memory flag yields one micro-op with op code 0 (compute), steered to the ALU queue (dst 0).
- R3: A compute macro-op with the memory flag set yields a load micro-op (op 1, dst 1, dep_prod 1) on a lane, followed directly on the next lane by its compute micro-op (op 0, dst 0, dep_wait 1) carrying the same tag.
- R4: A load-kind (kind 1) macro-op yields op 1 and a store-kind (kind 2) macro-op yields op 2, both steered to the AGU queue (dst 1). Every valid lane has dst 1 exactly when its op is not 0.
- R5: A double-class (class 1) macro-op yields two micro-ops of its kind, plus the single leading load when it is a compute op with the memory flag.
- R6: The wide flag never changes the number of micro-ops produced; it is copied onto every micro-op of its macro-op, as is the payload.
- R7: A microcoded macro-op (class 2 or 3) produces no lanes and raises `ucode_valid` with its payload. Inputs younger than it are not taken in that cycle; it and the older inputs are taken.
- R8: Valid lanes are packed from lane 0 in program order: older macro-ops, and earlier micro-ops within one macro-op, take lower lane indices.
- R9: If the group needs more ALU micro-ops than `alu_free` or more AGU micro-ops than `agu_free`, all `in_ready` bits are 0 and nothing of the group is emitted. A group that exactly fills the free counts is accepted.
- R10: Splits within an accepted group receive consecutive tags starting at the counter value. The counter advances by the number of splits accepted and wraps modulo 2^TAG_W. Lanes with neither dep_prod nor dep_wait carry tag 0.
- R11: `in_ready` reflects acceptance in the same cycle. Accepted micro-ops and the token appear on the outputs after the next clock edge, and a cycle without acceptance leaves all lanes and the token invalid and zero on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_IN | Macro-op slot valid, contiguous from slot 0 |
| in_class | input | 2*NUM_IN | Path class per slot: 0 single, 1 double, 2/3 microcoded |
| in_kind | input | 2*NUM_IN | Kind per slot: 0/3 compute, 1 load, 2 store |
| in_mem | input | NUM_IN | Memory source operand flag per slot |
| in_wide | input | NUM_IN | 256-bit vector flag per slot |
| in_payload | input | NUM_IN*PAY_W | Opaque payload per slot |
| alu_free | input | FREE_W | Free slots in the ALU scheduler queues |
| agu_free | input | FREE_W | Free slots in the AGU scheduler queues |
| in_ready | output | NUM_IN | Slot taken this cycle |
| out_valid | output | 3*NUM_IN | Lane holds a micro-op |
| out_dst | output | 3*NUM_IN | Target queue: 0 ALU, 1 AGU |
| out_op | output | 2*3*NUM_IN | Micro-op code: 0 compute, 1 load, 2 store |
| out_wide | output | 3*NUM_IN | Wide flag copied from the macro-op |
| out_payload | output | 3*NUM_IN*PAY_W | Payload copied from the macro-op |
| out_dep_tag | output | 3*NUM_IN*TAG_W | Dependency tag of a split pair |
| out_dep_prod | output | 3*NUM_IN | Lane produces the tagged value (split load) |
| out_dep_wait | output | 3*NUM_IN | Lane waits on the tagged value |
| ucode_valid | output | 1 | Microcode request token |
| ucode_payload | output | PAY_W | Payload of the microcoded macro-op |

## Verification
The checks take for granted that valid input slots are contiguous from slot 0, and that the free-slot counts describe the queues at the moment a group is offered. The queues are assumed to accept a microcode token whenever one is raised. The random stimulus draws a count of valid slots and fills only slots below it. It draws the free counts freely from 0 to 20, so both stalls and exact-fit acceptances occur often. Directed groups cover the split pair, the double class, wide operations, a microcoded op with younger inputs behind it, a full 18-lane group, and a free count one below the need.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    parameter int PAY_W     = 8;
    parameter int TAG_W     = 4;
    parameter int MAX_UOPS  = 3;

    typedef enum logic [1:0] {
        PC_SINGLE = 2'd0,
        PC_DOUBLE = 2'd1,
        PC_MICRO  = 2'd2,
        PC_MICRO2 = 2'd3
    } path_e;

    typedef enum logic [1:0] {
        MK_CALC  = 2'd0,
        MK_LOAD  = 2'd1,
        MK_STORE = 2'd2,
        MK_CALC2 = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        UO_CALC  = 2'd0,
        UO_LOAD  = 2'd1,
        UO_STORE = 2'd2,
        UO_RSVD  = 2'd3
    } uop_e;

    typedef enum logic {
        Q_ALU = 1'b0,
        Q_AGU = 1'b1
    } queue_e;

    typedef struct packed {
        path_e              cls;
        kind_e              kind;
        logic               mem;
        logic               wide;
        logic [PAY_W-1:0]   pay;
    } mop_t;

    typedef struct packed {
        logic               valid;
        queue_e             dst;
        uop_e               op;
        logic               wide;
        logic [PAY_W-1:0]   pay;
        logic [TAG_W-1:0]   tag;
        logic               dep_prod;
        logic               dep_wait;
    } uop_t;

    function automatic logic is_micro(mop_t m);
        return m.cls[1];
    endfunction

    function automatic logic is_calc(mop_t m);
        return (m.kind == MK_CALC) || (m.kind == MK_CALC2);
    endfunction

    function automatic logic splits(mop_t m);
        return !is_micro(m) && is_calc(m) && m.mem;
    endfunction

    function automatic queue_e queue_of(uop_e op);
        return (op == UO_CALC) ? Q_ALU : Q_AGU;
    endfunction

    function automatic uop_t make_uop(uop_e op, mop_t m, logic prod, logic wt);
        uop_t u;
        u          = '0;
        u.valid    = 1'b1;
        u.dst      = queue_of(op);
        u.op       = op;
        u.wide     = m.wide;
        u.pay      = m.pay;
        u.dep_prod = prod;
        u.dep_wait = wt;
        return u;
    endfunction

endpackage

// File: rtl/mcs_expand.sv
module mcs_expand
    import mcs_pkg::*;
(
    input  mop_t        mop,
    output uop_t        uops [MAX_UOPS],
    output logic [1:0]  n_alu,
    output logic [1:0]  n_agu,
    output logic        split
);

    always_comb begin
        int   cnt;
        uop_e mem_op;
        for (int k = 0; k < MAX_UOPS; k++) uops[k] = '0;
        cnt    = 0;
        mem_op = (mop.kind == MK_LOAD) ? UO_LOAD : UO_STORE;
        if (!is_micro(mop)) begin
            if (is_calc(mop)) begin
                if (mop.mem) begin
                    uops[cnt] = make_uop(UO_LOAD, mop, 1'b1, 1'b0);
                    cnt++;
                end
                uops[cnt] = make_uop(UO_CALC, mop, 1'b0, mop.mem);
                cnt++;
                if (mop.cls == PC_DOUBLE) begin
                    uops[cnt] = make_uop(UO_CALC, mop, 1'b0, mop.mem);
                    cnt++;
                end
            end else begin
                uops[0] = make_uop(mem_op, mop, 1'b0, 1'b0);
                if (mop.cls == PC_DOUBLE) uops[1] = make_uop(mem_op, mop, 1'b0, 1'b0);
            end
        end
    end

    always_comb begin
        n_alu = '0;
        n_agu = '0;
        for (int k = 0; k < MAX_UOPS; k++) begin
            if (uops[k].valid && uops[k].dst == Q_ALU) n_alu = n_alu + 2'd1;
            if (uops[k].valid && uops[k].dst == Q_AGU) n_agu = n_agu + 2'd1;
        end
    end

    assign split = splits(mop);

endmodule

// File: rtl/mcs_pack.sv
module mcs_pack
    import mcs_pkg::*;
#(
    parameter int NUM_IN = 6,
    localparam int LANES = MAX_UOPS * NUM_IN
) (
    input  uop_t                ex [NUM_IN][MAX_UOPS],
    input  logic [NUM_IN-1:0]   take,
    input  logic [NUM_IN-1:0]   split,
    input  logic [TAG_W-1:0]    tag_base,
    output uop_t                lanes [LANES],
    output logic [TAG_W-1:0]    n_split
);

    always_comb begin
        int pos;
        int sc;
        for (int l = 0; l < LANES; l++) lanes[l] = '0;
        pos = 0;
        sc  = 0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (take[i]) begin
                for (int k = 0; k < MAX_UOPS; k++) begin
                    if (ex[i][k].valid && pos < LANES) begin
                        lanes[pos] = ex[i][k];
                        if (ex[i][k].dep_prod || ex[i][k].dep_wait)
                            lanes[pos].tag = tag_base + TAG_W'(sc);
                        pos++;
                    end
                end
                if (split[i]) sc++;
            end
        end
        n_split = TAG_W'(sc);
    end

endmodule

// File: rtl/mop_crack_steer.sv
module mop_crack_steer
    import mcs_pkg::*;
#(
    parameter int NUM_IN = 6,
    parameter int FREE_W = 5,
    localparam int LANES = MAX_UOPS * NUM_IN
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_IN-1:0]           in_valid,
    input  logic [2*NUM_IN-1:0]         in_class,
    input  logic [2*NUM_IN-1:0]         in_kind,
    input  logic [NUM_IN-1:0]           in_mem,
    input  logic [NUM_IN-1:0]           in_wide,
    input  logic [NUM_IN*PAY_W-1:0]     in_payload,
    input  logic [FREE_W-1:0]           alu_free,
    input  logic [FREE_W-1:0]           agu_free,
    output logic [NUM_IN-1:0]           in_ready,
    output logic [LANES-1:0]            out_valid,
    output logic [LANES-1:0]            out_dst,
    output logic [2*LANES-1:0]          out_op,
    output logic [LANES-1:0]            out_wide,
    output logic [LANES*PAY_W-1:0]      out_payload,
    output logic [LANES*TAG_W-1:0]      out_dep_tag,
    output logic [LANES-1:0]            out_dep_prod,
    output logic [LANES-1:0]            out_dep_wait,
    output logic                        ucode_valid,
    output logic [PAY_W-1:0]            ucode_payload
);

    mop_t               mops  [NUM_IN];
    uop_t               ex    [NUM_IN][MAX_UOPS];
    logic [1:0]         na    [NUM_IN];
    logic [1:0]         ng    [NUM_IN];
    logic [NUM_IN-1:0]  sp;
    logic [NUM_IN-1:0]  group;
    logic               tok_hit;
    logic [PAY_W-1:0]   tok_pay;
    logic               accept;
    uop_t               lanes [LANES];
    logic [TAG_W-1:0]   n_split;
    logic [TAG_W-1:0]   dep_ctr;
    uop_t               out_q [LANES];
    logic               tok_q;
    logic [PAY_W-1:0]   tok_pay_q;
    logic [LANES-1:0]   alu_lane;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_IN; gi++) begin : g_slot
            assign mops[gi] = '{cls:  path_e'(in_class[2*gi +: 2]),
                                kind: kind_e'(in_kind[2*gi +: 2]),
                                mem:  in_mem[gi],
                                wide: in_wide[gi],
                                pay:  in_payload[PAY_W*gi +: PAY_W]};
            mcs_expand u_expand (
                .mop   (mops[gi]),
                .uops  (ex[gi]),
                .n_alu (na[gi]),
                .n_agu (ng[gi]),
                .split (sp[gi])
            );
        end
    endgenerate

    // Group selection: valid slots up to and including the first microcoded one.
    always_comb begin
        logic blocked;
        group   = '0;
        blocked = 1'b0;
        tok_hit = 1'b0;
        tok_pay = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (in_valid[i] && !blocked) begin
                group[i] = 1'b1;
                if (is_micro(mops[i])) begin
                    blocked = 1'b1;
                    tok_hit = 1'b1;
                    tok_pay = mops[i].pay;
                end
            end
        end
    end

    // All-or-nothing acceptance against free queue slots.
    always_comb begin
        int alu_need;
        int agu_need;
        alu_need = 0;
        agu_need = 0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (group[i]) begin
                alu_need += int'(na[i]);
                agu_need += int'(ng[i]);
            end
        end
        accept = (|group) && (alu_need <= int'(alu_free)) && (agu_need <= int'(agu_free));
    end

    assign in_ready = accept ? group : '0;

    mcs_pack #(.NUM_IN(NUM_IN)) u_pack (
        .ex       (ex),
        .take     (group),
        .split    (sp),
        .tag_base (dep_ctr),
        .lanes    (lanes),
        .n_split  (n_split)
    );

    always_ff @(posedge clk) begin
        if (rst || !accept) begin
            for (int l = 0; l < LANES; l++) out_q[l] <= '0;
            tok_q     <= 1'b0;
            tok_pay_q <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) out_q[l] <= lanes[l];
            tok_q     <= tok_hit;
            tok_pay_q <= tok_pay;
        end
        if (rst)         dep_ctr <= '0;
        else if (accept) dep_ctr <= dep_ctr + n_split;
    end

    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            assign out_valid[gi]                    = out_q[gi].valid;
            assign out_dst[gi]                      = out_q[gi].dst;
            assign out_op[2*gi +: 2]                = out_q[gi].op;
            assign out_wide[gi]                     = out_q[gi].wide;
            assign out_payload[PAY_W*gi +: PAY_W]   = out_q[gi].pay;
            assign out_dep_tag[TAG_W*gi +: TAG_W]   = out_q[gi].tag;
            assign out_dep_prod[gi]                 = out_q[gi].dep_prod;
            assign out_dep_wait[gi]                 = out_q[gi].dep_wait;
            assign alu_lane[gi]                     = out_q[gi].valid && out_q[gi].dst == Q_ALU;

            AST_QUEUE_MATCH: assert property (@(posedge clk) disable iff (rst)
                out_q[gi].valid |-> ((out_q[gi].dst == Q_AGU) == (out_q[gi].op != UO_CALC))); // R4

            if (gi < LANES - 1) begin : g_pair
                AST_LANES_PACKED: assert property (@(posedge clk) disable iff (rst)
                    !out_q[gi].valid |-> !out_q[gi+1].valid); // R8
                AST_DEP_PAIR: assert property (@(posedge clk) disable iff (rst)
                    (out_q[gi].valid && out_q[gi].dep_prod) |->
                    (out_q[gi+1].valid && out_q[gi+1].dep_wait &&
                     out_q[gi+1].tag == out_q[gi].tag)); // R3
            end
        end

        for (gi = 0; gi < NUM_IN - 1; gi++) begin : g_ustall
            AST_UCODE_STALL: assert property (@(posedge clk) disable iff (rst)
                (in_ready[gi] && in_class[2*gi+1]) |-> (in_ready[NUM_IN-1:gi+1] == '0)); // R7
        end
    endgenerate

    assign ucode_valid   = tok_q;
    assign ucode_payload = tok_pay_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (|in_ready) |=> ($countones(alu_lane) <= int'($past(alu_free)))); // R9

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !(|in_ready) |=> (out_valid == '0 && !ucode_valid)); // R11

endmodule

// File: tb/sim_mop_crack_steer.sv
module sim_mop_crack_steer;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 6;
    localparam int L   = 3 * N;
    localparam int PW  = 8;
    localparam int TW  = 4;
    localparam int FW  = 5;

    logic              clk = 1'b0;
    logic              rst;
    logic [N-1:0]      in_valid;
    logic [2*N-1:0]    in_class;
    logic [2*N-1:0]    in_kind;
    logic [N-1:0]      in_mem;
    logic [N-1:0]      in_wide;
    logic [N*PW-1:0]   in_payload;
    logic [FW-1:0]     alu_free;
    logic [FW-1:0]     agu_free;
    logic [N-1:0]      in_ready;
    logic [L-1:0]      out_valid;
    logic [L-1:0]      out_dst;
    logic [2*L-1:0]    out_op;
    logic [L-1:0]      out_wide;
    logic [L*PW-1:0]   out_payload;
    logic [L*TW-1:0]   out_dep_tag;
    logic [L-1:0]      out_dep_prod;
    logic [L-1:0]      out_dep_wait;
    logic              ucode_valid;
    logic [PW-1:0]     ucode_payload;

    mop_crack_steer #(.NUM_IN(N), .FREE_W(FW)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // expected next-cycle outputs
    logic [L-1:0]      e_valid, e_dst, e_wide, e_prod, e_wait;
    logic [2*L-1:0]    e_op;
    logic [L*PW-1:0]   e_pay;
    logic [L*TW-1:0]   e_tag;
    logic              e_tok;
    logic [PW-1:0]     e_tokpay;
    logic [N-1:0]      e_ready;
    logic [TW-1:0]     e_ctr;
    int                e_pos, e_alu, e_agu;

    task automatic check(string rq, logic [511:0] act, logic [511:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic add(int op, logic wd, logic [PW-1:0] p, logic prod, logic wt, logic [TW-1:0] tg);
        e_valid[e_pos]          = 1'b1;
        e_dst[e_pos]            = (op != 0);
        e_op[2*e_pos +: 2]      = 2'(op);
        e_wide[e_pos]           = wd;
        e_pay[PW*e_pos +: PW]   = p;
        e_prod[e_pos]           = prod;
        e_wait[e_pos]           = wt;
        e_tag[TW*e_pos +: TW]   = (prod || wt) ? tg : '0;
        if (op == 0) e_alu++; else e_agu++;
        e_pos++;
    endtask

    task automatic clear_exp();
        e_valid = '0; e_dst = '0; e_wide = '0; e_prod = '0; e_wait = '0;
        e_op = '0; e_pay = '0; e_tag = '0; e_tok = 1'b0; e_tokpay = '0;
    endtask

    // Reference model of R2..R11 written from the requirement text.
    task automatic model();
        bit blocked = 0;
        logic [N-1:0] grp = '0;
        logic [TW-1:0] sc = '0;
        bit acc;
        clear_exp();
        e_pos = 0; e_alu = 0; e_agu = 0;
        for (int i = 0; i < N; i++) begin
            if (in_valid[i] && !blocked) begin
                logic [1:0] c = in_class[2*i +: 2];
                logic [1:0] k = in_kind[2*i +: 2];
                logic [PW-1:0] p = in_payload[PW*i +: PW];
                logic w = in_wide[i];
                grp[i] = 1'b1;
                if (c >= 2) begin
                    blocked = 1; e_tok = 1'b1; e_tokpay = p;
                end else if (k == 0 || k == 3) begin
                    if (in_mem[i]) add(1, w, p, 1'b1, 1'b0, e_ctr + sc);
                    add(0, w, p, 1'b0, in_mem[i], e_ctr + sc);
                    if (c == 1) add(0, w, p, 1'b0, in_mem[i], e_ctr + sc);
                    if (in_mem[i]) sc++;
                end else begin
                    add((k == 1) ? 1 : 2, w, p, 1'b0, 1'b0, '0);
                    if (c == 1) add((k == 1) ? 1 : 2, w, p, 1'b0, 1'b0, '0);
                end
            end
        end
        acc = (|grp) && (e_alu <= int'(alu_free)) && (e_agu <= int'(agu_free));
        e_ready = acc ? grp : '0;
        if (!acc) clear_exp();
        else e_ctr = e_ctr + sc;
    endtask

    task automatic step(string rq);
        model();
        #1;
        check({rq, " R11 ready"}, 512'(in_ready), 512'(e_ready));
        @(negedge clk);
        check({rq, " lanes"}, 512'({out_valid, out_dst, out_op, out_wide, out_dep_prod, out_dep_wait}),
              512'({e_valid, e_dst, e_op, e_wide, e_prod, e_wait}));
        check({rq, " R6 payload"}, 512'(out_payload), 512'(e_pay));
        check({rq, " R10 tags"}, 512'(out_dep_tag), 512'(e_tag));
        check({rq, " R7 token"}, 512'({ucode_valid, ucode_payload}), 512'({e_tok, e_tokpay}));
    endtask

    task automatic clr_in();
        in_valid = '0; in_class = '0; in_kind = '0; in_mem = '0; in_wide = '0;
        in_payload = '0; alu_free = '1; agu_free = '1;
    endtask

    task automatic put(int i, int c, int k, bit m, bit w, logic [PW-1:0] p);
        in_valid[i] = 1'b1;
        in_class[2*i +: 2] = 2'(c);
        in_kind[2*i +: 2] = 2'(k);
        in_mem[i] = m;
        in_wide[i] = w;
        in_payload[PW*i +: PW] = p;
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_bad++;
                $display("FAIL watchdog expired");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        clr_in();
        e_ctr = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        check("R1 reset lanes", 512'({out_valid, out_dep_tag, out_payload}), 512'(0));
        check("R1 reset token", 512'({ucode_valid, ucode_payload}), 512'(0));
        rst = 1'b0;

        // R2: single compute without memory
        clr_in(); put(0, 0, 0, 0, 0, 8'h11); step("R2");
        check("R2 one lane", 512'(out_valid), 512'(1));
        check("R2 op/dst", 512'({out_op[1:0], out_dst[0]}), 512'(0));

        // R3 / R10: split pair with first tag 0 after reset
        clr_in(); put(0, 0, 0, 1, 0, 8'h22); step("R3");
        check("R3 load lane", 512'({out_op[1:0], out_dst[0], out_dep_prod[0]}), 512'({2'd1, 1'b1, 1'b1}));
        check("R3 calc lane", 512'({out_op[3:2], out_dst[1], out_dep_wait[1]}), 512'({2'd0, 1'b0, 1'b1}));
        check("R10 first tag", 512'(out_dep_tag[2*TW-1:0]), 512'(0));

        // R4: load and store kinds
        clr_in(); put(0, 0, 1, 1, 0, 8'h31); put(1, 0, 2, 0, 0, 8'h32); step("R4");
        check("R4 ops", 512'({out_op[3:0], out_dst[1:0]}), 512'({2'd2, 2'd1, 2'b11}));

        // R5 / R6: double compute with memory, wide
        clr_in(); put(0, 1, 3, 1, 1, 8'h41); step("R5");
        check("R5 three lanes", 512'(out_valid), 512'(7));
        check("R6 wide copied", 512'(out_wide), 512'(7));
        clr_in(); put(0, 0, 0, 0, 1, 8'h42); step("R6");
        check("R6 wide single", 512'(out_valid), 512'(1));

        // R7: microcoded op in slot 2 stalls slots 3..
        clr_in(); put(0, 0, 0, 0, 0, 8'h51); put(1, 0, 1, 0, 0, 8'h52);
        put(2, 2, 0, 0, 0, 8'h53); put(3, 0, 0, 0, 0, 8'h54);
        model(); #1;
        check("R7 ready mask", 512'(in_ready), 512'(4'b0111));
        @(negedge clk);
        check("R7 token", 512'({ucode_valid, ucode_payload}), 512'({1'b1, 8'h53}));
        check("R8 two lanes", 512'(out_valid), 512'(3));

        // R9: exact fit accepted, one short stalls
        clr_in();
        for (int i = 0; i < N; i++) put(i, 0, 0, 1, 0, 8'(8'h60 + i));
        alu_free = 5'd6; agu_free = 5'd6; step("R9 fit");
        check("R9 fit lanes", 512'(out_valid), 512'((1 << 12) - 1));
        agu_free = 5'd5; step("R9 short");
        check("R9 short ready", 512'(in_ready), 512'(0));
        check("R11 cleared", 512'({out_valid, ucode_valid}), 512'(0));

        // R8: full eighteen-lane group
        clr_in();
        for (int i = 0; i < N; i++) put(i, 1, 0, 1, i[0], 8'(8'h70 + i));
        step("R8 full");

        // random mix
        for (int t = 0; t < 3000; t++) begin
            int nv;
            clr_in();
            nv = int'($urandom % (N + 1));
            for (int i = 0; i < nv; i++) begin
                int r = int'($urandom % 8);
                int c = (r < 5) ? 0 : (r < 7) ? 1 : int'(2 + ($urandom % 2));
                put(i, c, int'($urandom % 4), 1'($urandom), 1'($urandom), 8'($urandom));
            end
            alu_free = 5'($urandom % 21);
            agu_free = 5'($urandom % 21);
            step("R8 random");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule